// File: doc/BRIEF.md
# Twisted-Ring Decade/Octal Divider with One-Hot Slots

This block divides an incoming clock by a fixed modulus of ten or eight. It keeps its count as a Johnson (twisted-ring) code in a shift register of half the modulus. One parameter picks the modulus, and the number of ring stages follows from it. Every count value has its own output line, called a slot, and that line is high only while the counter holds that value. A square-wave carry output completes one period per full turn of the ring, so it can clock a following divider.

The count moves forward on a rising clock edge only while the active-low enable input is low. An active-high reset, sampled on the clock edge, returns the ring to count zero. Reset wins over the enable. Each slot output is the AND of two ring bits that sit next to each other. The ring changes one bit per step, so at most one slot output moves high and one moves low on each edge. The next-state function also steers any pattern that is not a legal Johnson code back into the legal sequence, so no reset is needed to recover from one.

Top module: `johnson_divider`

## Requirements
- R1: Parameter DIVIDE sets the modulus. DIVIDE=10 gives a five-stage ring and ten slot outputs. DIVIDE=8 gives a four-stage ring and eight slot outputs.
- R2: When `rst` is 1 at a rising edge, the next output state is count 0: slot bit 0 high, all other slots low and `carry_out` high. This holds whatever the level of `en_n`.
- R3: When `en_n` is 0 at a rising edge and `rst` is 0, the count moves from k to (k+1) mod DIVIDE. The high slot moves from bit k to bit (k+1) mod DIVIDE.
- R4: When `en_n` is 1 at a rising edge and `rst` is 0, the count and all outputs keep their values.
- R5: From the first reset onward, exactly one slot bit is high. Slot bit k is high exactly while the count equals k, which is one full clock cycle per visit when the counter is enabled continuously.
- R6: `carry_out` is 1 for counts 0 to DIVIDE/2-1 and 0 for counts DIVIDE/2 to DIVIDE-1. Under continuous enable it has a period of DIVIDE clocks and a duty cycle of exactly half.
- R7: `carry_out` rises only on the step that wraps the count from DIVIDE-1 to 0.
- R8: The ring's next-state function sends every stage pattern to a legal Johnson code within DIVIDE steps. A legal code is one whose adjacent-bit changes number at most one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset to count 0, active high |
| en_n | input | 1 | Count enable, active low |
| slot | output | DIVIDE | One-hot decoded count |
| carry_out | output | 1 | Square wave, one period per DIVIDE counts |

## Verification
The bench runs the ring past the wrap from DIVIDE-1 to 0. A shift that fails to feed back the inverted last stage would drop to an all-zero or all-one slot vector there, or would skip a slot. It holds `en_n` high partway through a count, where an enable of the wrong polarity would let the count creep forward. It asserts reset both with the enable active and with it inactive, which catches a reset that is gated by the enable. It measures the carry's duty cycle and its number of rising edges over a window of 40 clocks for both moduli, and it walks every possible stage pattern through the next-state function, which exposes a ring that never leaves an illegal code.

// File: rtl/johnson_pkg.sv
`timescale 1ns/1ps
package johnson_pkg;

    localparam int JC_MAX_STAGES = 8;

    typedef logic [JC_MAX_STAGES-1:0] jc_ring_t;

    typedef enum logic [1:0] {
        STEP_CLEAR  = 2'd0,
        STEP_HOLD   = 2'd1,
        STEP_SHIFT  = 2'd2,
        STEP_REPAIR = 2'd3
    } jc_step_e;

    typedef struct packed {
        logic     legal;
        jc_step_e step;
    } jc_ctrl_t;

    // Legal Johnson codes have at most one change between neighbouring bits.
    function automatic logic jc_is_legal(input jc_ring_t q, input int stages);
        int edges;
        edges = 0;
        for (int i = 0; i < JC_MAX_STAGES - 1; i++) begin
            if ((i < stages - 1) && (q[i] != q[i+1])) edges++;
        end
        return (edges <= 1);
    endfunction

    // Shift toward the top, feeding the inverted top stage into bit 0;
    // any illegal pattern is steered back to the zero code.
    function automatic jc_ring_t jc_next(input jc_ring_t q, input int stages);
        jc_ring_t n;
        n = '0;
        if (jc_is_legal(q, stages)) begin
            for (int i = 1; i < JC_MAX_STAGES; i++) begin
                if (i < stages) n[i] = q[i-1];
            end
            n[0] = ~q[stages-1];
        end
        return n;
    endfunction

    function automatic jc_step_e jc_pick_step(input logic clear, input logic hold_n,
                                              input logic legal);
        if (clear)       return STEP_CLEAR;
        else if (!legal) return STEP_REPAIR;
        else if (hold_n) return STEP_HOLD;
        else             return STEP_SHIFT;
    endfunction

endpackage

// File: rtl/jc_state_reg.sv
`timescale 1ns/1ps
module jc_state_reg
    import johnson_pkg::*;
#(
    parameter int STAGES = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_n,
    output logic [STAGES-1:0] ring
);

    logic [STAGES-1:0] ring_q;
    logic [STAGES-1:0] ring_d;
    jc_ring_t          wide_q;
    jc_ring_t          wide_next;
    jc_ctrl_t          ctrl;

    always_comb begin
        wide_q = '0;
        wide_q[STAGES-1:0] = ring_q;
    end

    assign wide_next  = jc_next(wide_q, STAGES);
    assign ctrl.legal = jc_is_legal(wide_q, STAGES);
    assign ctrl.step  = jc_pick_step(rst, en_n, ctrl.legal);

    always_comb begin
        unique case (ctrl.step)
            STEP_CLEAR:  ring_d = '0;
            STEP_HOLD:   ring_d = ring_q;
            STEP_SHIFT:  ring_d = wide_next[STAGES-1:0];
            STEP_REPAIR: ring_d = wide_next[STAGES-1:0];
            default:     ring_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        ring_q <= ring_d;
    end

    assign ring = ring_q;

    // R2: a sampled reset leaves the ring at the zero code
    assert_reset_zero_R2: assert property (@(posedge clk)
        rst |=> (ring_q == '0));

    // R4: a disabled edge leaves a legal ring unchanged
    assert_hold_ring_R4: assert property (@(posedge clk) disable iff (rst)
        (en_n && ctrl.legal) |=> $stable(ring_q));

endmodule

// File: rtl/jc_slot_decode.sv
`timescale 1ns/1ps
module jc_slot_decode #(
    parameter int STAGES = 5,
    localparam int SLOTS = 2 * STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] ring,
    output logic [SLOTS-1:0]  slot
);

    // Each slot is a two-input AND of neighbouring ring bits.
    assign slot[0]      = ~ring[STAGES-1] & ~ring[0];
    assign slot[STAGES] =  ring[STAGES-1] &  ring[0];

    for (genvar k = 1; k < STAGES; k++) begin : g_pair
        assign slot[k]          =  ring[k-1] & ~ring[k];
        assign slot[STAGES + k] = ~ring[k-1] &  ring[k];
    end

    // R5: exactly one slot line high once reset has run
    assert_slot_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $countones(slot) == 1);

endmodule

// File: rtl/jc_carry.sv
`timescale 1ns/1ps
module jc_carry #(
    parameter int STAGES = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] ring,
    input  logic              wrap_slot,
    output logic              carry
);

    // The inverted top stage is high for the first half of the cycle.
    assign carry = ~ring[STAGES-1];

    // R7: carry may only rise on entering count 0
    assert_carry_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(carry) |-> wrap_slot);

endmodule

// File: rtl/johnson_divider.sv
`timescale 1ns/1ps
module johnson_divider #(
    parameter int DIVIDE = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_n,
    output logic [DIVIDE-1:0] slot,
    output logic              carry_out
);

    localparam int STAGES = DIVIDE / 2;

    logic [STAGES-1:0] ring;
    logic [DIVIDE-1:0] slot_rot;

    jc_state_reg #(.STAGES(STAGES)) u_state (
        .clk  (clk),
        .rst  (rst),
        .en_n (en_n),
        .ring (ring)
    );

    jc_slot_decode #(.STAGES(STAGES)) u_decode (
        .clk  (clk),
        .rst  (rst),
        .ring (ring),
        .slot (slot)
    );

    jc_carry #(.STAGES(STAGES)) u_carry (
        .clk       (clk),
        .rst       (rst),
        .ring      (ring),
        .wrap_slot (slot[0]),
        .carry     (carry_out)
    );

    assign slot_rot = {slot[DIVIDE-2:0], slot[DIVIDE-1]};

    // R3: an enabled edge moves the high slot up by one, wrapping at the top
    assert_slot_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(en_n)) |-> (slot == $past(slot_rot)));

    // R4: a disabled edge keeps every output
    assert_slot_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(en_n)) |-> ($stable(slot) && $stable(carry_out)));

    // R6: carry high exactly in the lower half of the count
    assert_carry_half_R6: assert property (@(posedge clk) disable iff (rst)
        carry_out == (|slot[STAGES-1:0]));

endmodule

// File: tb/test_johnson_divider.sv
`timescale 1ns/1ps
module test_johnson_divider;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_n = 1'b1;
    logic [9:0] slot10;
    logic [7:0] slot8;
    logic       carry10;
    logic       carry8;

    int checks = 0;
    int failures = 0;
    int c10 = 0;
    int c8 = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    johnson_divider #(.DIVIDE(10)) i_johnson_divider (
        .clk(clk), .rst(rst), .en_n(en_n), .slot(slot10), .carry_out(carry10)
    );

    johnson_divider #(.DIVIDE(8)) i_johnson_divider_8 (
        .clk(clk), .rst(rst), .en_n(en_n), .slot(slot8), .carry_out(carry8)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst) begin
            c10 = 0;
            c8  = 0;
        end else if (!en_n) begin
            c10 = (c10 + 1) % 10;
            c8  = (c8 + 1) % 8;
        end
        @(negedge clk);
    endtask

    task automatic check_outputs(input string tag);
        logic [9:0] e10;
        logic [7:0] e8;
        e10 = 10'(1) << c10;
        e8  = 8'(1) << c8;
        check(slot10 == e10, tag, "slot10", 32'(slot10), 32'(e10));
        check(carry10 == (c10 < 5), tag, "carry10", 32'(carry10), 32'(c10 < 5));
        check(slot8 == e8, tag, "slot8", 32'(slot8), 32'(e8));
        check(carry8 == (c8 < 4), tag, "carry8", 32'(carry8), 32'(c8 < 4));
    endtask

    task automatic t_reset();
        rst = 1'b1; en_n = 1'b0;
        tick(); tick();
        check_outputs("R2 reset state");
        check($bits(slot10) == 10 && $bits(slot8) == 8, "R1", "slot widths",
              32'($bits(slot10) + $bits(slot8)), 32'(18));
        rst = 1'b0;
    endtask

    task automatic t_run_wrap();
        en_n = 1'b0;
        for (int i = 0; i < 25; i++) begin
            tick();
            check_outputs("R3 R5 advance and wrap");
        end
    endtask

    task automatic t_hold();
        en_n = 1'b0;
        tick(); tick();
        en_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick();
            check_outputs("R4 hold while en_n high");
        end
        en_n = 1'b0;
        tick();
        check_outputs("R3 resume after hold");
    endtask

    task automatic t_mid_reset();
        en_n = 1'b0;
        tick(); tick(); tick();
        rst = 1'b1;
        tick();
        check_outputs("R2 reset mid-count with enable");
        rst = 1'b0;
        tick(); tick(); tick(); tick();
        en_n = 1'b1; rst = 1'b1;
        tick();
        check_outputs("R2 reset with enable inactive");
        rst = 1'b0; en_n = 1'b0;
    endtask

    task automatic t_carry();
        int hi10 = 0, hi8 = 0, rise10 = 0, rise8 = 0;
        logic p10, p8;
        rst = 1'b1; tick(); rst = 1'b0;
        en_n = 1'b0;
        p10 = carry10; p8 = carry8;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (carry10) hi10++;
            if (carry8) hi8++;
            if (carry10 && !p10) begin
                rise10++;
                check(slot10[0], "R7", "carry10 rise off wrap", 32'(slot10), 32'(1));
            end
            if (carry8 && !p8) begin
                rise8++;
                check(slot8[0], "R7", "carry8 rise off wrap", 32'(slot8), 32'(1));
            end
            p10 = carry10; p8 = carry8;
        end
        check(hi10 == 20, "R6", "carry10 high cycles", 32'(hi10), 32'(20));
        check(hi8 == 20, "R6", "carry8 high cycles", 32'(hi8), 32'(20));
        check(rise10 == 4, "R6", "carry10 periods", 32'(rise10), 32'(4));
        check(rise8 == 5, "R6", "carry8 periods", 32'(rise8), 32'(5));
    endtask

    function automatic logic [7:0] legal_code(input int s, input int c);
        logic [7:0] v;
        v = '0;
        for (int i = 0; i < s; i++) begin
            if (c <= s) v[i] = (i < c);
            else        v[i] = (i >= c - s);
        end
        return v;
    endfunction

    task automatic t_recovery(input int s);
        int bad = 0;
        for (int p = 0; p < (1 << s); p++) begin
            logic [7:0] q;
            bit hit;
            q = 8'(p);
            hit = 1'b0;
            for (int k = 0; k <= 2 * s && !hit; k++) begin
                for (int c = 0; c < 2 * s; c++) begin
                    if (q == legal_code(s, c)) hit = 1'b1;
                end
                if (!hit) q = johnson_pkg::jc_next(q, s);
            end
            if (!hit) bad++;
        end
        check(bad == 0, "R8", $sformatf("unrecovered patterns for %0d stages", s),
              32'(bad), 32'(0));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_run_wrap();
        t_hold();
        t_mid_reset();
        t_carry();
        t_recovery(5);
        t_recovery(4);
        finish_run();
    end

endmodule